// File: doc/BRIEF.md
# Shadow Image Loader with Additive Checksum

This block keeps a local copy of a 64-word, 16-bit configuration image that lives in an external word-addressed memory (typically reached through a serial non-volatile memory master). On command it fetches every word into an internal shadow array and accumulates a wrapping 16-bit sum. The image counts as valid only when two conditions hold: the sum hits a fixed target, and a two-bit signature field in one control word carries the expected code. When the checksum fails, the signature held in the shadow copy is wiped, so the cached image stays invalid.

A second command recomputes the checksum word from the first 63 words and writes it back to the last address. Hosts can also push single words out to the external memory. Every such write, including the checksum write, wipes the cached signature. The next lookup must therefore fetch the image again. A lookup port serves words from the shadow array. It triggers a fetch only when the cached signature is not valid, and it answers zero for indices beyond the image or for an image that is still invalid.

Top module: `shadowImageLoader`

## Requirements
- R1: A fetch reads addresses 0 through 63 in ascending order. Only one access is outstanding at a time. `memReq` stays high, with `memAddr`, `memWe` and `memWdata` stable, until `memAck`.
- R2: The sum of the fetched words wraps modulo 65536. After any fetch, `lastSumOk` is 1 exactly when the sum of all 64 words equals 16'hBABA.
- R3: `imgValid` is 1 when bits 15:14 of shadow word 10 equal 2'b01. A fetch whose checksum fails clears those two bits, so `imgValid` is 0 after it even when the fetched word 10 carries 2'b01.
- R4: An update command reads words 0 to 62, then writes 16'hBABA minus their wrapped sum to address 63.
- R5: Every completed write (host write or checksum write) clears bits 15:14 of shadow word 10, so `imgValid` is 0 after it.
- R6: A lookup with `lkIdx` below 64 and `imgValid` at 1 returns the shadow word and makes no memory access. `lkAck` pulses in the cycle after acceptance.
- R7: A lookup with `lkIdx` below 64 and `imgValid` at 0 first fetches all 64 words. It then returns the shadow word if the image has become valid, and zero otherwise.
- R8: A lookup with `lkIdx` of 64 or more returns zero and makes no memory access.
- R9: `busy` is high while a fetch or an update is in progress. `loadReq` and `updReq` are accepted only while the sequencer is idle, and they are ignored otherwise.
- R10: When several requests meet an idle sequencer, the priority is update, then load, then host write, then lookup. Requests that lose stay pending while their level is held.
- R11: After reset, `busy`, `imgValid`, `lastSumOk` and `memReq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadReq | input | 1 | Single-cycle fetch command |
| updReq | input | 1 | Single-cycle checksum update command |
| busy | output | 1 | Fetch or update in progress |
| imgValid | output | 1 | Cached signature is valid |
| lastSumOk | output | 1 | Checksum result of the latest fetch |
| wrReq | input | 1 | Host write request, held until `wrAck` |
| wrAddr | input | 6 | Host write address |
| wrData | input | 16 | Host write data |
| wrAck | output | 1 | Host write completed |
| lkReq | input | 1 | Lookup request, held until `lkAck` |
| lkIdx | input | 7 | Lookup index |
| lkAck | output | 1 | Lookup answer valid |
| lkData | output | 16 | Lookup answer |
| memReq | output | 1 | Word access request to external memory |
| memWe | output | 1 | Access is a write |
| memAddr | output | 6 | Access address |
| memWdata | output | 16 | Write data |
| memAck | input | 1 | Access complete, read data valid |
| memRdata | input | 16 | Read data |

## Verification
The collision that matters is a host write and a lookup that reach the idle sequencer in the same cycle while the cached image is valid. The bench raises both requests on the same edge. It then judges three things: the write acknowledge must arrive before the lookup acknowledge; the lookup must cause a full 64-word fetch, because the write wiped the signature; and the answer must be zero, because the altered word breaks the checksum. A load pulse and an update pulse are also issued together. The bench confirms from the external access counts that only the update ran, with 63 reads and one write to address 63.

// File: rtl/shadowImgPkg.sv
package shadowImgPkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_RESP} seqState_t;
  typedef enum logic [1:0] {OP_LOAD, OP_UPD, OP_LOOK, OP_HOST} opKind_t;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrSum;
    logic capRd;
    logic finLoad;
    logic wrDone;
  } pathCtl_t;
endpackage

// File: rtl/shadowImgPath.sv
module shadowImgPath
  import shadowImgPkg::*;
#(
  parameter int WORDS = 64,
  parameter int DW = 16,
  parameter int AW = $clog2(WORDS),
  parameter logic [DW-1:0] SUM_TARGET = 16'hBABA,
  parameter int SIG_WORD = 10,
  parameter int SIG_HI = 15,
  parameter int SIG_W = 2,
  parameter logic [SIG_W-1:0] SIG_OK = 2'b01
) (
  input  logic          clk,
  input  logic          rstN,
  input  pathCtl_t      ctl,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] memRdata,
  input  logic [AW-1:0] lkSel,
  output logic [DW-1:0] ckWord,
  output logic          sigValid,
  output logic          lastSumOk,
  output logic [DW-1:0] lkWord
);
  logic [DW-1:0] shadow [WORDS];
  logic [DW-1:0] sumQ;
  logic [DW-1:0] sumNxt;
  logic          sumHit;
  logic          clrSig;

  assign sumNxt = sumQ + memRdata;
  assign sumHit = (sumNxt == SUM_TARGET);
  assign ckWord = SUM_TARGET - sumQ;
  assign clrSig = ctl.wrDone || (ctl.finLoad && !sumHit);
  assign sigValid = (shadow[SIG_WORD][SIG_HI -: SIG_W] == SIG_OK);
  assign lkWord = shadow[lkSel];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumQ <= '0;
      lastSumOk <= 1'b0;
    end else begin
      if (ctl.clrSum) sumQ <= '0;
      else if (ctl.capRd) sumQ <= sumNxt;
      if (ctl.finLoad) lastSumOk <= sumHit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) shadow[i] <= '0;
    end else begin
      if (ctl.capRd) shadow[addr] <= memRdata;
      if (clrSig) shadow[SIG_WORD][SIG_HI -: SIG_W] <= '0;
    end
  end

  // R3: a failing fetch leaves the cached signature invalid
  a_r3_bad_sum_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finLoad && !sumHit) |=> !sigValid);
  // R2: the flag follows the completed fetch's comparison
  a_r2_flag_follows: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finLoad && sumHit) |=> lastSumOk);
endmodule

// File: rtl/shadowImgCtrl.sv
module shadowImgCtrl
  import shadowImgPkg::*;
#(
  parameter int WORDS = 64,
  parameter int DW = 16,
  parameter int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          loadReq,
  input  logic          updReq,
  input  logic          wrReq,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          lkReq,
  input  logic [AW:0]   lkIdx,
  input  logic          memAck,
  input  logic          sigValid,
  input  logic [DW-1:0] ckWord,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          busy,
  output logic          wrAck,
  output logic          lkAck,
  output logic [AW-1:0] addrOut,
  output pathCtl_t      ctl
);
  localparam logic [AW-1:0] A_LAST = AW'(WORDS - 1);
  localparam logic [AW-1:0] A_PEN = AW'(WORDS - 2);
  localparam logic [AW:0] IDX_LIM = (AW+1)'(WORDS);

  seqState_t stateQ, stateD;
  opKind_t opQ, opD;
  logic [AW-1:0] addrQ, addrD;
  logic [AW-1:0] lastAddr;
  logic idxInRange;

  assign lastAddr = (opQ == OP_UPD) ? A_PEN : A_LAST;
  assign idxInRange = (lkIdx < IDX_LIM);

  always_comb begin
    stateD = stateQ;
    opD = opQ;
    addrD = addrQ;
    ctl = '0;
    case (stateQ)
      ST_IDLE: begin
        if (updReq) begin
          opD = OP_UPD; addrD = '0; ctl.clrSum = 1'b1; stateD = ST_RD;
        end else if (loadReq) begin
          opD = OP_LOAD; addrD = '0; ctl.clrSum = 1'b1; stateD = ST_RD;
        end else if (wrReq) begin
          opD = OP_HOST; stateD = ST_WR;
        end else if (lkReq) begin
          if (!idxInRange || sigValid) stateD = ST_RESP;
          else begin
            opD = OP_LOOK; addrD = '0; ctl.clrSum = 1'b1; stateD = ST_RD;
          end
        end
      end
      ST_RD: begin
        if (memAck) begin
          ctl.capRd = 1'b1;
          if (addrQ == lastAddr) begin
            if (opQ == OP_UPD) begin
              stateD = ST_WR; addrD = A_LAST;
            end else begin
              ctl.finLoad = 1'b1;
              stateD = (opQ == OP_LOOK) ? ST_RESP : ST_IDLE;
            end
          end else begin
            addrD = addrQ + 1'b1;
          end
        end
      end
      ST_WR: begin
        if (memAck) begin
          ctl.wrDone = 1'b1; stateD = ST_IDLE;
        end
      end
      ST_RESP: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      opQ <= OP_LOAD;
      addrQ <= '0;
    end else begin
      stateQ <= stateD;
      opQ <= opD;
      addrQ <= addrD;
    end
  end

  assign memReq = (stateQ == ST_RD) || (stateQ == ST_WR);
  assign memWe = (stateQ == ST_WR);
  assign memAddr = (opQ == OP_HOST) ? wrAddr : addrQ;
  assign memWdata = (opQ == OP_HOST) ? wrData : ckWord;
  assign busy = (stateQ == ST_RD) || (stateQ == ST_WR && opQ == OP_UPD);
  assign wrAck = (stateQ == ST_WR) && (opQ == OP_HOST) && memAck;
  assign lkAck = (stateQ == ST_RESP);
  assign addrOut = addrQ;

  // R1: a pending access holds its request and address
  a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));
  // R1: reads inside one fetch step upward by one
  a_r1_ascend: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RD && memAck && addrQ != lastAddr) |=> (memAddr == $past(memAddr) + 1'b1));
  // R4: the checksum write targets the last word
  a_r4_ck_addr: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && opQ == OP_UPD) |-> (memAddr == A_LAST));
  // R9: no lookup answer while a fetch or update runs
  a_r9_busy_no_answer: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !lkAck);
endmodule

// File: rtl/shadowImageLoader.sv
module shadowImageLoader
  import shadowImgPkg::*;
#(
  parameter int WORDS = 64,
  parameter int DW = 16,
  parameter int AW = $clog2(WORDS),
  parameter logic [DW-1:0] SUM_TARGET = 16'hBABA,
  parameter int SIG_WORD = 10,
  parameter int SIG_HI = 15,
  parameter int SIG_W = 2,
  parameter logic [SIG_W-1:0] SIG_OK = 2'b01
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          loadReq,
  input  logic          updReq,
  output logic          busy,
  output logic          imgValid,
  output logic          lastSumOk,
  input  logic          wrReq,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  output logic          wrAck,
  input  logic          lkReq,
  input  logic [AW:0]   lkIdx,
  output logic          lkAck,
  output logic [DW-1:0] lkData,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic          memAck,
  input  logic [DW-1:0] memRdata
);
  localparam logic [AW:0] IDX_LIM = (AW+1)'(WORDS);

  pathCtl_t ctl;
  logic [AW-1:0] seqAddr;
  logic [DW-1:0] ckWord;
  logic [DW-1:0] lkWord;
  logic sigValid;

  shadowImgCtrl #(.WORDS(WORDS), .DW(DW), .AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN), .loadReq(loadReq), .updReq(updReq),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData),
    .lkReq(lkReq), .lkIdx(lkIdx), .memAck(memAck), .sigValid(sigValid),
    .ckWord(ckWord), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .busy(busy), .wrAck(wrAck), .lkAck(lkAck),
    .addrOut(seqAddr), .ctl(ctl)
  );

  shadowImgPath #(.WORDS(WORDS), .DW(DW), .AW(AW), .SUM_TARGET(SUM_TARGET),
                  .SIG_WORD(SIG_WORD), .SIG_HI(SIG_HI), .SIG_W(SIG_W),
                  .SIG_OK(SIG_OK)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addr(seqAddr), .memRdata(memRdata),
    .lkSel(lkIdx[AW-1:0]), .ckWord(ckWord), .sigValid(sigValid),
    .lastSumOk(lastSumOk), .lkWord(lkWord)
  );

  assign imgValid = sigValid;
  assign lkData = (lkAck && (lkIdx < IDX_LIM) && sigValid) ? lkWord : '0;

  // R5: any completed write leaves the image invalid
  a_r5_write_invalidates: assert property (@(posedge clk) disable iff (!rstN)
    (memAck && memWe) |=> !imgValid);
  // R8: out-of-range lookups answer zero
  a_r8_oob_zero: assert property (@(posedge clk) disable iff (!rstN)
    (lkAck && lkIdx >= IDX_LIM) |-> (lkData == '0));
  // R7: an invalid image never returns a nonzero word
  a_r7_invalid_zero: assert property (@(posedge clk) disable iff (!rstN)
    (lkAck && !imgValid) |-> (lkData == '0));
endmodule

// File: tb/sim_shadowImageLoader.sv
`timescale 1ns/1ps
module sim_shadowImageLoader;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadReq = 1'b0, updReq = 1'b0;
  logic busy, imgValid, lastSumOk;
  logic wrReq = 1'b0;
  logic [5:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic wrAck;
  logic lkReq = 1'b0;
  logic [6:0] lkIdx = '0;
  logic lkAck;
  logic [15:0] lkData;
  logic memReq, memWe;
  logic [5:0] memAddr;
  logic [15:0] memWdata;
  logic memAck = 1'b0;
  logic [15:0] memRdata = '0;

  always #2.5 clk = ~clk;

  shadowImageLoader u0 (.*);

  // external memory model, two wait cycles per access
  logic [15:0] mem [64];
  int rdCnt = 0, wrCnt = 0, ascErr = 0, lat = 0;
  logic [5:0] lastRd = '0, lastWrAddr = '0;
  always @(posedge clk) begin
    memAck <= 1'b0;
    if (memReq && !memAck) begin
      if (lat == 2) begin
        lat <= 0;
        memAck <= 1'b1;
        if (memWe) begin
          mem[memAddr] <= memWdata;
          wrCnt <= wrCnt + 1;
          lastWrAddr <= memAddr;
        end else begin
          memRdata <= mem[memAddr];
          rdCnt <= rdCnt + 1;
          if (memAddr != 6'd0 && memAddr != 6'(lastRd + 6'd1)) ascErr <= ascErr + 1;
          lastRd <= memAddr;
        end
      end else lat <= lat + 1;
    end
  end

  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] sumTo(input int last);
    logic [15:0] s = '0;
    for (int i = 0; i <= last; i++) s = s + mem[i];
    return s;
  endfunction

  task automatic waitIdle();
    int g = 0;
    while (busy && g < 2000) begin @(negedge clk); g++; end
    if (g >= 2000) chk(1'b0, "watchdog busy", 0, 0);
  endtask

  task automatic cmd(input bit ld, input bit up, output bit sawBusy);
    @(negedge clk); loadReq = ld; updReq = up;
    @(negedge clk); loadReq = 1'b0; updReq = 1'b0;
    sawBusy = busy;
    waitIdle();
  endtask

  task automatic lookup(input logic [6:0] idx, output logic [15:0] data);
    int g = 0;
    @(negedge clk); lkReq = 1'b1; lkIdx = idx;
    do begin @(negedge clk); g++; end while (!lkAck && g < 2000);
    if (g >= 2000) chk(1'b0, "watchdog lookup", 0, 0);
    data = lkData;
    lkReq = 1'b0;
  endtask

  task automatic hostWrite(input logic [5:0] a, input logic [15:0] d);
    int g = 0;
    @(negedge clk); wrReq = 1'b1; wrAddr = a; wrData = d;
    do begin @(negedge clk); g++; end while (!wrAck && g < 2000);
    if (g >= 2000) chk(1'b0, "watchdog write", 0, 0);
    wrReq = 1'b0;
    @(negedge clk);
  endtask

  // lookup vectors walked after a good fetch
  localparam int NV = 8;
  localparam logic [6:0] LK_IDX [NV] = '{7'd0, 7'd1, 7'd10, 7'd31, 7'd62, 7'd63, 7'd64, 7'd127};

  initial begin
    logic [15:0] d, expCk;
    int r0, w0, wCyc, lCyc, cyc;
    bit sb, wDone, lDone;
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 291 + 7);
    mem[10] = 16'h4A5C;
    mem[63] = 16'hBABA - sumTo(62);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy == 1'b0 && memReq == 1'b0, "R11 busy/memReq after reset", {busy, memReq}, 0);
    chk(imgValid == 1'b0 && lastSumOk == 1'b0, "R11 flags after reset", {imgValid, lastSumOk}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R7 first lookup fetches the image
    r0 = rdCnt;
    lookup(7'd5, d);
    chk(rdCnt - r0 == 64, "R7 fetch on invalid cache", rdCnt - r0, 64);
    chk(d == mem[5], "R7 word after fetch", d, mem[5]);
    chk(ascErr == 0, "R1 ascending reads", ascErr, 0);
    chk(lastSumOk == 1'b1, "R2 good sum flagged", lastSumOk, 1);
    chk(imgValid == 1'b1, "R3 valid after good fetch", imgValid, 1);

    // R6 / R8 table of lookups from a valid cache
    r0 = rdCnt;
    for (int v = 0; v < NV; v++) begin
      logic [15:0] e;
      e = (LK_IDX[v] < 7'd64) ? mem[LK_IDX[v][5:0]] : 16'h0000;
      lookup(LK_IDX[v], d);
      chk(d == e, (LK_IDX[v] < 7'd64) ? "R6 cached word" : "R8 out-of-range zero", d, e);
    end
    chk(rdCnt == r0, "R6 no access on valid cache", rdCnt - r0, 0);

    // R5 host write invalidates
    w0 = wrCnt;
    hostWrite(6'd20, mem[20] ^ 16'h00F0);
    chk(wrCnt - w0 == 1, "R5 write issued", wrCnt - w0, 1);
    chk(imgValid == 1'b0, "R5 invalid after host write", imgValid, 0);

    // R7 / R2 / R3 reload with broken checksum
    r0 = rdCnt;
    lookup(7'd20, d);
    chk(rdCnt - r0 == 64, "R7 reload after write", rdCnt - r0, 64);
    chk(d == 16'h0, "R7 zero on bad image", d, 0);
    chk(lastSumOk == 1'b0, "R2 bad sum flagged", lastSumOk, 0);
    chk(imgValid == 1'b0, "R3 bad sum clears signature", imgValid, 0);

    // R4 update writes checksum
    expCk = 16'hBABA - sumTo(62);
    r0 = rdCnt; w0 = wrCnt;
    cmd(1'b0, 1'b1, sb);
    chk(sb == 1'b1, "R9 busy during update", sb, 1);
    chk(rdCnt - r0 == 63 && wrCnt - w0 == 1, "R4 access counts", {rdCnt - r0, wrCnt - w0}, {63, 1});
    chk(lastWrAddr == 6'd63 && mem[63] == expCk, "R4 checksum word", mem[63], expCk);
    chk(imgValid == 1'b0, "R5 invalid after checksum write", imgValid, 0);

    // R2 / R3 load restores validity
    cmd(1'b1, 1'b0, sb);
    chk(sb == 1'b1, "R9 busy during load", sb, 1);
    chk(lastSumOk == 1'b1 && imgValid == 1'b1, "R3 valid after load", {lastSumOk, imgValid}, 2'b11);

    // R9 load pulse during update is dropped
    r0 = rdCnt; w0 = wrCnt;
    @(negedge clk); updReq = 1'b1;
    @(negedge clk); updReq = 1'b0;
    @(negedge clk); @(negedge clk); loadReq = 1'b1;
    @(negedge clk); loadReq = 1'b0;
    waitIdle();
    repeat (3) @(negedge clk);
    chk(rdCnt - r0 == 63 && wrCnt - w0 == 1, "R9 load ignored while busy", rdCnt - r0, 63);

    // R10 load and update together: update wins
    r0 = rdCnt; w0 = wrCnt;
    cmd(1'b1, 1'b1, sb);
    repeat (3) @(negedge clk);
    chk(rdCnt - r0 == 63 && wrCnt - w0 == 1, "R10 update beats load", rdCnt - r0, 63);

    // R3 good sum with bad signature (field 2'b10)
    hostWrite(6'd10, 16'h8A5C);
    cmd(1'b0, 1'b1, sb);
    cmd(1'b1, 1'b0, sb);
    chk(lastSumOk == 1'b1 && imgValid == 1'b0, "R3 bad signature", {lastSumOk, imgValid}, 2'b10);
    r0 = rdCnt;
    lookup(7'd3, d);
    chk(rdCnt - r0 == 64 && d == 16'h0, "R7 refetch then zero", d, 0);

    // restore, then R10 host write and lookup in the same cycle
    hostWrite(6'd10, 16'h4A5C);
    cmd(1'b0, 1'b1, sb);
    cmd(1'b1, 1'b0, sb);
    chk(imgValid == 1'b1, "R3 valid after restore", imgValid, 1);
    r0 = rdCnt; w0 = wrCnt;
    wCyc = -1; lCyc = -1; cyc = 0; wDone = 0; lDone = 0;
    @(negedge clk);
    wrReq = 1'b1; wrAddr = 6'd40; wrData = mem[40] + 16'd1;
    lkReq = 1'b1; lkIdx = 7'd7;
    while (!(wDone && lDone) && cyc < 2000) begin
      @(negedge clk); cyc++;
      if (wrAck && !wDone) begin wDone = 1; wCyc = cyc; wrReq = 1'b0; end
      if (lkAck && !lDone) begin lDone = 1; lCyc = cyc; d = lkData; lkReq = 1'b0; end
    end
    if (cyc >= 2000) chk(1'b0, "watchdog collision", 0, 0);
    chk(wCyc >= 0 && wCyc < lCyc, "R10 write served before lookup", wCyc, lCyc);
    chk(rdCnt - r0 == 64 && wrCnt - w0 == 1, "R10 lookup refetches after write", rdCnt - r0, 64);
    chk(d == 16'h0, "R10 lookup answer zero", d, 0);

    // R8 out-of-range on invalid cache: no fetch
    r0 = rdCnt;
    lookup(7'd70, d);
    chk(rdCnt == r0 && d == 16'h0, "R8 no fetch out of range", rdCnt - r0, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule